// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block inspects one 16-bit instruction halfword. It decides whether that halfword is a conditional branch and, if it is, whether the branch is taken. It makes that decision by testing the selected condition against the negative (N), zero (Z), carry (C) and overflow (V) flags. It also forms the PC-relative destination and the address the fetch unit should use next. Two codes in the condition field are reserved and never branch: one marks an undefined instruction and the other a software interrupt. The block flags each of these so that exception logic further on can act on it.

All outputs are registered, with one clock of latency from the inputs. The block does not update the program counter, flush the pipeline or enter exceptions. It only reports the outcome.

Top module: `bcond_eval`

## Requirements
- R1: `br_match` is 1 exactly when bits [15:12] of the instruction equal 4'hD. The condition code is bits [11:8] and the signed offset is bits [7:0].
- R2: `br_target` equals the instruction address plus 4, plus the 8-bit offset sign-extended and multiplied by 2, modulo 2^ADDR_W.
- R3: For codes 0 to 7, a single flag is tested. 0 needs Z=1, 1 needs Z=0, 2 needs C=1, 3 needs C=0, 4 needs N=1, 5 needs N=0, 6 needs V=1 and 7 needs V=0.
- R4: Code 8 is taken when C=1 and Z=0. Code 9 is taken when C=0 or Z=1.
- R5: Code 10 is taken when N equals V. Code 11 is taken when N differs from V.
- R6: Code 12 is taken when Z=0 and N equals V. Code 13 is taken when Z=1 or N differs from V.
- R7: Code 14 never branches and raises `undef_hit`, but only on a matching encoding.
- R8: Code 15 never branches and raises `trap_hit`, but only on a matching encoding.
- R9: `br_next` equals `br_target` when the branch is taken, and the instruction address plus 2 otherwise.
- R10: A halfword that does not match sets `br_taken`, `undef_hit` and `trap_hit` to 0, whatever its low 12 bits and the flags are.
- R11: Each output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction halfword |
| addr | input | ADDR_W | Address of the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| br_match | output | 1 | Halfword is a conditional-branch encoding |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | ADDR_W | PC-relative destination |
| br_next | output | ADDR_W | Address to fetch next |
| undef_hit | output | 1 | Reserved undefined code seen |
| trap_hit | output | 1 | Software-interrupt code seen |

## Verification
The hardest cases to reach are the combined conditions (codes 8, 9, 12 and 13). In each of these a single flag changes the outcome only when another flag holds a particular value. The stimulus therefore sweeps all sixteen condition codes against all sixteen flag combinations, so every case where one flag masks another is covered. Offset wraparound is reached by sweeping all 256 offsets at addresses next to zero and next to the top of the address space. Reserved codes and non-matching opcodes are driven with every flag set, to show that no branch and no stray indication can leak through.

// File: rtl/bcond_eval.sv
module bcond_eval #(
  parameter int ADDR_W = 32,
  parameter logic [3:0] OPC = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              br_match,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] br_next,
  output logic              undef_hit,
  output logic              trap_hit
);
  localparam int OFF_W = 8;
  localparam logic [ADDR_W-1:0] PF_STEP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(2);

  logic [3:0]        cond;
  logic              hit, nv_same, base, pass;
  logic [ADDR_W-1:0] disp, dest, seq;

  assign hit     = instr[15:12] == OPC;
  assign cond    = instr[11:8];
  assign nv_same = flag_n ~^ flag_v;

  always_comb begin
    case (cond[3:1])
      3'd0:    base = flag_z;
      3'd1:    base = flag_c;
      3'd2:    base = flag_n;
      3'd3:    base = flag_v;
      3'd4:    base = flag_c & ~flag_z;
      3'd5:    base = nv_same;
      3'd6:    base = ~flag_z & nv_same;
      default: base = 1'b0;
    endcase
  end

  assign pass = hit & (cond[3:1] != 3'd7) & (base ^ cond[0]);
  assign disp = {{(ADDR_W-OFF_W-1){instr[OFF_W-1]}}, instr[OFF_W-1:0], 1'b0};
  assign dest = addr + PF_STEP + disp;
  assign seq  = addr + SEQ_STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_match  <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
      br_next   <= '0;
      undef_hit <= 1'b0;
      trap_hit  <= 1'b0;
    end else begin
      br_match  <= hit;
      br_taken  <= pass;
      br_target <= dest;
      br_next   <= pass ? dest : seq;
      undef_hit <= hit & (cond == 4'hE);
      trap_hit  <= hit & (cond == 4'hF);
    end
  end
endmodule

// File: rtl/bcond_eval_chk.sv
module bcond_eval_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       instr,
  input logic [ADDR_W-1:0] addr,
  input logic              br_match,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic [ADDR_W-1:0] br_next,
  input logic              undef_hit,
  input logic              trap_hit
);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  AST_MATCH_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (br_match == ($past(instr[15:12]) == 4'hD))); // R1
  AST_TAKEN_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_match); // R10
  AST_UNDEF_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    undef_hit |-> (br_match && !br_taken && !trap_hit)); // R7
  AST_TRAP_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |-> (br_match && !br_taken)); // R8
  AST_TAKEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (br_next == br_target)); // R9
  AST_FALLTHRU_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (br_taken || br_next == $past(addr) + TWO)); // R9
  AST_RESERVED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(instr[11:9]) != 3'd7) || !br_taken)); // R7
endmodule

bind bcond_eval bcond_eval_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .addr(addr),
  .br_match(br_match), .br_taken(br_taken), .br_target(br_target),
  .br_next(br_next), .undef_hit(undef_hit), .trap_hit(trap_hit)
);

// File: tb/bcond_eval_test.sv
module bcond_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] addr = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic        br_match, br_taken, undef_hit, trap_hit;
  logic [31:0] br_target, br_next;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bcond_eval #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .addr(addr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .br_match(br_match), .br_taken(br_taken), .br_target(br_target),
    .br_next(br_next), .undef_hit(undef_hit), .trap_hit(trap_hit)
  );

  function automatic bit ref_take(input logic [3:0] c, input bit n, input bit z, input bit cy, input bit v);
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy && !z;
      4'h9: return !cy || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ins, input logic [31:0] a, input logic [3:0] f);
    @(negedge clk);
    instr = ins; addr = a;
    {flag_n, flag_z, flag_c, flag_v} = f;
    @(negedge clk);
  endtask

  task automatic verify_all(input string req);
    bit m, t;
    logic [31:0] tgt, nxt;
    int off;
    m = instr[15:12] == 4'hD;
    t = m && ref_take(instr[11:8], flag_n, flag_z, flag_c, flag_v);
    off = $signed(instr[7:0]) * 2;
    tgt = addr + 32'd4 + off;
    nxt = t ? tgt : addr + 32'd2;
    chk("R1", "match", {31'b0, br_match}, {31'b0, m});
    chk(req, "taken", {31'b0, br_taken}, {31'b0, t});
    chk("R2", "target", br_target, tgt);
    chk("R9", "next", br_next, nxt);
    chk("R7", "undef", {31'b0, undef_hit}, {31'b0, m && instr[11:8] == 4'hE});
    chk("R8", "trap", {31'b0, trap_hit}, {31'b0, m && instr[11:8] == 4'hF});
  endtask

  function automatic string req_of(input logic [3:0] c);
    if (c < 8) return "R3";
    if (c < 10) return "R4";
    if (c < 12) return "R5";
    if (c < 14) return "R6";
    if (c == 14) return "R7";
    return "R8";
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    instr = 16'hD0FF; addr = 32'h1234;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset match", {31'b0, br_match}, 32'd0);
    chk("R11", "reset taken", {31'b0, br_taken}, 32'd0);
    chk("R11", "reset target", br_target, 32'd0);
    chk("R11", "reset next", br_next, 32'd0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8: every code against every flag set
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        apply({4'hD, 4'(c), 8'h05}, 32'h0000_1000 + 32'(c * 64), 4'(f));
        verify_all(req_of(4'(c)));
      end

    // R2 offsets near zero and top of address space
    for (int o = 0; o < 256; o++) begin
      apply({8'hD0, 8'(o)}, 32'h0000_0010, 4'b0100);
      verify_all("R2");
      apply({8'hD1, 8'(o)}, 32'hFFFF_FFF0, 4'b0000);
      verify_all("R2");
    end

    // R10 non-matching opcodes with every flag set
    for (int op = 0; op < 16; op++)
      if (op != 13)
        for (int c = 0; c < 16; c++) begin
          apply({4'(op), 4'(c), 8'h80}, 32'h8000_0000, 4'hF);
          verify_all("R10");
          chk("R10", "no taken", {31'b0, br_taken}, 32'd0);
        end

    // R11 single-cycle latency: output tracks the new input after one edge
    @(negedge clk);
    instr = 16'hD0_02; addr = 32'h100; {flag_n, flag_z, flag_c, flag_v} = 4'b0100;
    @(posedge clk); #1;
    chk("R11", "latency taken", {31'b0, br_taken}, 32'd1);
    chk("R11", "latency next", br_next, 32'h108);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule